// File: doc/BRIEF.md
# Eight-Bit ALU with Status Flags

This block is the arithmetic and logic unit of a small 8-bit microcontroller core. Each cycle it can take a destination operand, a second operand (a register value or an immediate), and an operation code. In the same cycle it returns the result and a write-back strobe. The core uses the strobe to decide whether the destination register is overwritten. Compares produce flags but no write-back.

The block holds the status register itself. On the clock edge where a recognised operation is valid, the register takes new half-carry, sign, overflow, negative, zero and carry flags. The two upper bits are never touched by an operation.

The carry-chained subtracts can only clear the zero flag, never set it. A compare of the low bytes followed by carry-chained compares of the higher bytes therefore leaves zero set only when every byte matched. A separate load port lets the core write the whole status register, for example to restore it or to prepare a carry-in.

Top module: `alu8_core`

## Requirements
- R1: Operation code 0 adds. The result is d+r modulo 256. With the vector K = (d&r)|(r&~res)|(~res&d), H is K bit 3 and C is K bit 7. V is bit 7 of (d&r&~res)|(~d&~r&res).
- R2: Operation codes 1 (subtract) and 3 (compare) form d-r. With the vector B = (~d&r)|(r&res)|(res&~d), H is B bit 3 and C is B bit 7. V is bit 7 of (d&~r&~res)|(~d&r&res). Z is set exactly when the difference is zero.
- R3: Operation codes 2 (subtract with carry) and 4 (compare with carry) form d-r-1 when the stored C is 1, and d-r otherwise. H, C and V follow the R2 equations applied to that difference.
- R4: For codes 2 and 4, Z becomes 0 when the difference is nonzero and otherwise keeps its previous value. A 16-bit compare done as code 3 on the low bytes and then code 4 on the high bytes leaves Z=1 exactly when the words are equal, and C=1 exactly when the first word is below the second (unsigned).
- R5: For every recognised operation, N is bit 7 of the result and S equals N XOR V.
- R6: wr_en is 1 in a cycle where op_valid is 1 and the code is 0, 1, 2, 5, 6, 7 or 8. Compares (codes 3 and 4) keep it 0.
- R7: The logical operations are AND (code 5), OR (code 6), XOR (code 7) and clear (code 8, result 0). They force V to 0, set Z and N from the result, and leave C and H unchanged.
- R8: Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5. Bits 7:6 are never changed by an operation.
- R9: The status register changes only on a clock edge. It takes new flags only when op_valid is 1 with a recognised code. Codes 9 to 15 give wr_en=0 and leave the status register unchanged.
- R10: When sreg_ld is 1 at an edge, the status register takes sreg_din, even if an operation is valid in the same cycle.
- R11: When imm_sel is 1, imm_val replaces rr_val as the second operand.
- R12: During reset (rst_n low) the status register is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code, 0 to 8 recognised |
| rd_val | input | 8 | Destination operand d |
| rr_val | input | 8 | Register second operand |
| imm_val | input | 8 | Immediate second operand |
| imm_sel | input | 1 | Select imm_val as second operand |
| sreg_ld | input | 1 | Load the whole status register |
| sreg_din | input | 8 | Value for the status load |
| result | output | 8 | Operation result (combinational) |
| wr_en | output | 1 | Write result back to destination |
| sreg | output | 8 | Status register |

## Verification
On every cycle, assertions check the following: the S=N^V relation after an operation, that bits 7:6 stay untouched, that the register holds when no operation or load occurs, that load wins over an operation, that compares give no write-back, that Z never rises in the carry-chained subtracts, and that the logical operations clear V and keep C. Whether H, C and V have the right values for given operands can only be shown by the bench scenarios. The bench recomputes these flags from widened sums and signs. The same applies to the end state of multi-byte compares, the immediate selection and the ignored operation codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned MSB     = DW - 1;
  localparam int unsigned HALF    = DW / 2 - 1;
  localparam int unsigned SW      = 8;

  // status bit positions
  localparam int unsigned F_C = 0;
  localparam int unsigned F_Z = 1;
  localparam int unsigned F_N = 2;
  localparam int unsigned F_V = 3;
  localparam int unsigned F_S = 4;
  localparam int unsigned F_H = 5;

  typedef logic [DW-1:0] word_t;
  typedef logic [SW-1:0] stat_t;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_SBC = 4'd2,
    OP_CMP = 4'd3,
    OP_CPC = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_CLR = 4'd8
  } alu_op_e;

  function automatic word_t add_cvec(word_t d, word_t r, word_t s);
    return (d & r) | (r & ~s) | (~s & d);
  endfunction

  function automatic word_t sub_bvec(word_t d, word_t r, word_t s);
    return (~d & r) | (r & s) | (s & ~d);
  endfunction

  function automatic logic add_ovf(word_t d, word_t r, word_t s);
    word_t t;
    t = (d & r & ~s) | (~d & ~r & s);
    return t[MSB];
  endfunction

  function automatic logic sub_ovf(word_t d, word_t r, word_t s);
    word_t t;
    t = (d & ~r & ~s) | (~d & r & s);
    return t[MSB];
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
(
  input  word_t a,
  input  word_t b,
  input  logic  sub,
  input  logic  cin,
  output word_t sum,
  output word_t cvec,
  output logic  ovf
);
  always_comb begin
    if (sub) begin
      sum  = a - b - word_t'(cin);
      cvec = sub_bvec(a, b, sum);
      ovf  = sub_ovf(a, b, sum);
    end else begin
      sum  = a + b;
      cvec = add_cvec(a, b, sum);
      ovf  = add_ovf(a, b, sum);
    end
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  word_t   a,
  input  word_t   b,
  input  alu_op_e op,
  output word_t   y
);
  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  upd,
  input  logic  ld,
  input  stat_t din,
  input  stat_t nx,
  output stat_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (ld)  q <= din;
    else if (upd) q <= nx;
  end

  // R9: hold without update or load
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !ld) |=> $stable(q));
  // R10: load takes priority
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q == $past(din)));
  // R8: upper bits untouched by operations
  a_r8_top_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !ld) |=> (q[SW-1:F_H+1] == $past(q[SW-1:F_H+1])));
  // R5: sign relation after an operation
  a_r5_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !ld) |=> (q[F_S] == (q[F_N] ^ q[F_V])));
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [3:0] op_code,
  input  logic [7:0] rd_val,
  input  logic [7:0] rr_val,
  input  logic [7:0] imm_val,
  input  logic       imm_sel,
  input  logic       sreg_ld,
  input  logic [7:0] sreg_din,
  output logic [7:0] result,
  output logic       wr_en,
  output logic [7:0] sreg
);
  alu_op_e op;
  assign op = alu_op_e'(op_code);

  logic is_add, is_sub, chain, is_cmp, is_logic, known;
  always_comb begin
    is_add   = (op == OP_ADD);
    chain    = (op == OP_SBC) || (op == OP_CPC);
    is_cmp   = (op == OP_CMP) || (op == OP_CPC);
    is_sub   = (op == OP_SUB) || chain || (op == OP_CMP);
    is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_CLR);
    known    = is_add || is_sub || is_logic;
  end

  word_t opnd_b;
  assign opnd_b = imm_sel ? imm_val : rr_val;

  stat_t sreg_q;
  logic  carry_in;
  assign carry_in = chain & sreg_q[F_C];

  word_t as_sum, as_vec, lg_y;
  logic  as_ovf;

  alu8_addsub u_as (
    .a(rd_val), .b(opnd_b), .sub(is_sub), .cin(carry_in),
    .sum(as_sum), .cvec(as_vec), .ovf(as_ovf)
  );

  alu8_logic u_lg (.a(rd_val), .b(opnd_b), .op(op), .y(lg_y));

  word_t res;
  assign res = is_logic ? lg_y : as_sum;

  // named internal events
  logic res_zero, z_keep, new_h, new_c, new_v, new_n, new_z;
  assign res_zero = (res == '0);
  assign z_keep   = chain;
  always_comb begin
    new_h = is_logic ? sreg_q[F_H] : as_vec[HALF];
    new_c = is_logic ? sreg_q[F_C] : as_vec[MSB];
    new_v = is_logic ? 1'b0 : as_ovf;
    new_n = res[MSB];
    new_z = z_keep ? (res_zero & sreg_q[F_Z]) : res_zero;
  end

  stat_t sreg_nx;
  always_comb begin
    sreg_nx      = sreg_q;
    sreg_nx[F_C] = new_c;
    sreg_nx[F_Z] = new_z;
    sreg_nx[F_N] = new_n;
    sreg_nx[F_V] = new_v;
    sreg_nx[F_S] = new_n ^ new_v;
    sreg_nx[F_H] = new_h;
  end

  logic upd;
  assign upd = op_valid & known;

  alu8_status u_st (
    .clk(clk), .rst_n(rst_n), .upd(upd), .ld(sreg_ld),
    .din(sreg_din), .nx(sreg_nx), .q(sreg_q)
  );

  assign result = res;
  assign wr_en  = upd & ~is_cmp;
  assign sreg   = sreg_q;

  // R6: compares never write back
  a_r6_cmp_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 4'd3 || op_code == 4'd4)) |-> !wr_en);
  // R9: unknown codes never write back
  a_r9_unknown_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code > 4'd8) |-> !wr_en);
  // R4: carry-chained subtracts never raise Z
  a_r4_z_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && z_keep && !sreg_ld && !sreg_q[F_Z]) |=> !sreg[F_Z]);
  // R7: logical ops clear V and keep C and H
  a_r7_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_logic && !sreg_ld) |=>
      (!sreg[F_V] && sreg[F_C] == $past(sreg_q[F_C]) && sreg[F_H] == $past(sreg_q[F_H])));
endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, op_valid, imm_sel, sreg_ld, wr_en;
  logic [3:0] op_code;
  logic [7:0] rd_val, rr_val, imm_val, sreg_din, result, sreg;

  alu8_core u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .rd_val(rd_val), .rr_val(rr_val), .imm_val(imm_val), .imm_sel(imm_sel),
    .sreg_ld(sreg_ld), .sreg_din(sreg_din),
    .result(result), .wr_en(wr_en), .sreg(sreg)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // reference: {we, result, status}, from widened arithmetic
  function automatic logic [16:0] model(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic [7:0] s);
    logic [7:0] r;
    logic c, h, v, z, n, we;
    int ci;
    c = s[0]; h = s[5]; v = 1'b0; r = 8'h00;
    we = (op <= 4'd8) && op != 4'd3 && op != 4'd4;
    if (op > 4'd8) return {1'b0, 8'h00, s};
    case (op)
      4'd0: begin
        r = 8'(int'(a) + int'(b));
        c = (int'(a) + int'(b)) > 255;
        h = (int'(a[3:0]) + int'(b[3:0])) > 15;
        v = (a[7] == b[7]) && (r[7] != a[7]);
      end
      4'd1, 4'd2, 4'd3, 4'd4: begin
        ci = ((op == 4'd2 || op == 4'd4) && s[0]) ? 1 : 0;
        r = 8'(int'(a) - int'(b) - ci);
        c = int'(a) < int'(b) + ci;
        h = int'(a[3:0]) < int'(b[3:0]) + ci;
        v = (a[7] != b[7]) && (r[7] != a[7]);
      end
      4'd5: r = a & b;
      4'd6: r = a | b;
      4'd7: r = a ^ b;
      default: r = 8'h00;
    endcase
    z = (r == 8'h00);
    if (op == 4'd2 || op == 4'd4) z = z && s[1];
    n = r[7];
    return {we, r, s[7:6], h, n ^ v, v, n, z, c};
  endfunction

  task automatic run_op(string req, logic [3:0] op, logic [7:0] a, logic [7:0] b,
                        bit imm, bit load, logic [7:0] s0);
    logic [16:0] e;
    if (load) begin
      @(negedge clk); sreg_ld = 1'b1; sreg_din = s0;
      @(negedge clk); sreg_ld = 1'b0;
    end else begin
      @(negedge clk);
    end
    e = model(op, a, b, sreg);
    op_valid = 1'b1; op_code = op; rd_val = a; imm_sel = imm;
    if (imm) begin rr_val = ~b; imm_val = b; end
    else     begin rr_val = b;  imm_val = ~b; end
    #1;
    chk({req, " wr_en"}, {7'd0, wr_en}, {7'd0, e[16]});
    if (op <= 4'd8) chk({req, " result"}, result, e[15:8]);
    @(negedge clk);
    op_valid = 1'b0;
    chk({req, " status"}, sreg, e[7:0]);
  endtask

  function automatic string tag(logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1, 4'd3: return "R2/R5/R6";
      4'd2, 4'd4: return "R3/R4";
      default: return "R7/R8";
    endcase
  endfunction

  task automatic t_reset;
    rst_n = 1'b0; op_valid = 0; sreg_ld = 0; imm_sel = 0;
    op_code = 0; rd_val = 0; rr_val = 0; imm_val = 0; sreg_din = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R12 reset status", sreg, 8'h00);
    rst_n = 1'b1;
  endtask

  task automatic t_random;
    for (int op = 0; op <= 8; op++)
      for (int cin = 0; cin < 2; cin++)
        for (int k = 0; k < 20; k++) begin
          logic [7:0] s0;
          s0 = 8'($urandom);
          s0[0] = cin[0];
          run_op(tag(4'(op)), 4'(op), 8'($urandom), 8'($urandom), k[0], 1'b1, s0);
        end
  endtask

  task automatic t_corners;
    run_op("R1 carry half", 4'd0, 8'hFF, 8'h01, 0, 1, 8'h00);
    run_op("R1 overflow", 4'd0, 8'h7F, 8'h01, 0, 1, 8'h00);
    run_op("R2 borrow", 4'd1, 8'h00, 8'h01, 0, 1, 8'h00);
    run_op("R2 overflow", 4'd1, 8'h80, 8'h01, 0, 1, 8'h00);
    run_op("R3 zero minus carry", 4'd2, 8'h00, 8'h00, 0, 1, 8'h03);
    run_op("R4 z kept", 4'd4, 8'h10, 8'h10, 0, 1, 8'h02);
    run_op("R4 z not set", 4'd4, 8'h10, 8'h10, 0, 1, 8'h00);
    run_op("R7 clear", 4'd8, 8'h5A, 8'hA5, 0, 1, 8'h3F);
    run_op("R11 immediate", 4'd1, 8'h40, 8'h11, 1, 1, 8'h00);
    run_op("R8 top bits", 4'd0, 8'h01, 8'h02, 0, 1, 8'hC0);
  endtask

  task automatic t_multibyte;
    logic [15:0] xs [6] = '{16'h1234, 16'h1234, 16'h1200, 16'h0034, 16'h00FF, 16'hFFFF};
    logic [15:0] ys [6] = '{16'h1234, 16'h1235, 16'h1234, 16'h1234, 16'h0100, 16'hFFFF};
    for (int i = 0; i < 6; i++) begin
      run_op("R2 low", 4'd3, xs[i][7:0], ys[i][7:0], 0, 1, 8'h00);
      run_op("R4 high", 4'd4, xs[i][15:8], ys[i][15:8], 0, 0, 8'h00);
      chk("R4 word equal", {7'd0, sreg[1]}, {7'd0, xs[i] == ys[i]});
      chk("R4 word below", {7'd0, sreg[0]}, {7'd0, xs[i] < ys[i]});
    end
  endtask

  task automatic t_unknown;
    for (int op = 9; op < 16; op++)
      run_op("R9 unknown code", 4'(op), 8'h33, 8'h44, 0, 1, 8'h5A);
  endtask

  task automatic t_idle_and_load;
    @(negedge clk); sreg_ld = 1; sreg_din = 8'h21;
    @(negedge clk); sreg_ld = 0;
    op_valid = 0; op_code = 4'd1; rd_val = 8'h00; rr_val = 8'h01;
    #1 chk("R6 idle wr_en", {7'd0, wr_en}, 8'h00);
    @(negedge clk);
    chk("R9 idle hold", sreg, 8'h21);
    op_valid = 1; op_code = 4'd0; rd_val = 8'hFF; rr_val = 8'hFF;
    sreg_ld = 1; sreg_din = 8'h84;
    @(negedge clk);
    op_valid = 0; sreg_ld = 0;
    chk("R10 load wins", sreg, 8'h84);
  endtask

  initial begin
    t_reset();
    t_corners();
    t_random();
    t_multibyte();
    t_unknown();
    t_idle_and_load();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule